// File: doc/BRIEF.md
# Test Access Port with Debug Register Window

This block is a boundary-scan test access port that runs entirely on the test clock. The mode-select line walks a sixteen-state controller. A 6-bit instruction register then chooses the data path placed between the serial input and the serial output. Four paths are built in:

- a one-bit bypass stage;
- a fixed 32-bit identification code;
- a 32-bit debug window;
- a hand-off to an external boundary chain.

The debug window is selected by a private opcode whose low four bits name one of sixteen 32-bit debug registers held outside the block. Capture copies the named register into the window. Update writes the window back to it. A host can therefore read or modify any debug register with one instruction scan and one data scan.

The boundary chain itself sits outside the block. For the EXTEST and SAMPLE/PRELOAD instructions the block only drives select, capture, shift and update strobes, and takes the chain's serial output back to its own serial output. The external chain takes its serial input straight from `tdi`.

The serial protocol cannot be stalled, so the parallel ports carry no valid/ready handshake. Each strobe is a level that lasts exactly one controller state, and the receiving side must act on it within that state. A write is taken on the falling clock edge while `dbg_wr_en` is high. Read data must be valid while `dbg_rd_en` is high, and it is sampled on the rising edge that leaves that state.

Top module: `dbg_tap_top`

## Requirements
- R1: The controller moves on each rising edge of `tck` according to `tms` along the standard sixteen-state graph. Driving `trst_n` low forces Test-Logic-Reset at once and selects IDCODE, whatever the current state.
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state, which reloads IDCODE as the current instruction.
- R3: The instruction register is 6 bits wide. Capture-IR loads 6'b000001 into it, Shift-IR shifts it out least-significant bit first, and a new instruction takes effect only in Update-IR.
- R4: IDCODE (6'b011111) loads the 32-bit `ID_CODE` parameter in Capture-DR and shifts it out least-significant bit first. Bits shifted in never change the code returned by the next scan.
- R5: BYPASS (6'b111111) and every opcode not listed in R4, R6 or R8 place a one-bit stage on the path. This stage captures 0 in Capture-DR, so an n-bit scan of d returns {d[n-2:0], 1'b0}.
- R6: DEBUG (6'b10ssss) drives `dbg_addr` = ssss and raises `dbg_rd_en` in Capture-DR. It loads `dbg_rdata` into the 32-bit window on the rising edge that leaves Capture-DR, and the window then shifts out least-significant bit first.
- R7: Under DEBUG, `dbg_wr_en` is high only in Update-DR, with `dbg_wdata` holding the 32 bits shifted in. The addressed register is written on the falling edge in that state and no other register changes.
- R8: EXTEST (6'b000000) and SAMPLE/PRELOAD (6'b000001) raise `bs_select`, and EXTEST alone raises `bs_extest`. `bs_capture`, `bs_shift` and `bs_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and `bs_tdo` is routed to `tdo`.
- R9: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is high only in Shift-IR and Shift-DR, and `tdo` is 0 whenever `tdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_oe | output | 1 | Serial output enable |
| dbg_addr | output | 4 | Debug register index from the instruction |
| dbg_rd_en | output | 1 | Debug read strobe (Capture-DR under DEBUG) |
| dbg_rdata | input | 32 | Content of the addressed debug register |
| dbg_wr_en | output | 1 | Debug write strobe (Update-DR under DEBUG) |
| dbg_wdata | output | 32 | Data to write to the addressed debug register |
| bs_select | output | 1 | External boundary chain is on the path |
| bs_extest | output | 1 | Chain outputs drive the pins (EXTEST) |
| bs_capture | output | 1 | Chain capture strobe |
| bs_shift | output | 1 | Chain shift enable |
| bs_update | output | 1 | Chain update strobe, act on falling edge |
| bs_tdo | input | 1 | Serial output of the external chain |

## Verification
The hardest case to reach is a debug write-back that must land in one register only, on the falling edge, while the other fifteen stay untouched. It needs an instruction scan, a full 32-bit data scan and a pass through Update-DR, all in the right order. The bench models the debug bank with distinct preset values and drives complete IR and DR scans through `tms`. After each scan it reads back both the written register and one of its neighbours. The five-ones reset is entered from the middle of Shift-DR under BYPASS, and the effect is seen through the IDCODE scan that follows.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

  typedef enum logic [3:0] {
    TAP_RESET   = 4'd0,
    TAP_IDLE    = 4'd1,
    TAP_SEL_DR  = 4'd2,
    TAP_CAP_DR  = 4'd3,
    TAP_SH_DR   = 4'd4,
    TAP_EX1_DR  = 4'd5,
    TAP_PAU_DR  = 4'd6,
    TAP_EX2_DR  = 4'd7,
    TAP_UPD_DR  = 4'd8,
    TAP_SEL_IR  = 4'd9,
    TAP_CAP_IR  = 4'd10,
    TAP_SH_IR   = 4'd11,
    TAP_EX1_IR  = 4'd12,
    TAP_PAU_IR  = 4'd13,
    TAP_EX2_IR  = 4'd14,
    TAP_UPD_IR  = 4'd15
  } tap_state_e;

  localparam int IR_W = 6;

  localparam logic [IR_W-1:0] OP_EXTEST  = 6'b000000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 6'b000001;
  localparam logic [IR_W-1:0] OP_IDCODE  = 6'b011111;
  localparam logic [IR_W-1:0] OP_BYPASS  = 6'b111111;
  localparam logic [1:0]      OP_DBG_HI  = 2'b10;
  localparam logic [IR_W-1:0] IR_CAPTURE = 6'b000001;

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
  import dbg_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    unique case (state)
      TAP_RESET:  nxt = tms ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:   nxt = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR: nxt = tms ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:  nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR: nxt = tms ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: nxt = tms ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: nxt = tms ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR: nxt = tms ? TAP_RESET  : TAP_CAP_IR;
      TAP_CAP_IR: nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:  nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR: nxt = tms ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: nxt = tms ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: nxt = tms ? TAP_UPD_IR : TAP_SH_IR;
      TAP_UPD_IR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
      default:    nxt = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TAP_RESET;
    else         state <= nxt;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state == TAP_RESET)); // R2

  AST_RESET_EXIT: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TAP_RESET && !tms) |=> (state == TAP_IDLE)); // R1

endmodule

// File: rtl/dbg_tap_ir.sv
module dbg_tap_ir
  import dbg_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == TAP_CAP_IR) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == TAP_SH_IR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                   ir_q <= OP_IDCODE;
    else if (state == TAP_RESET)   ir_q <= OP_IDCODE;
    else if (state == TAP_UPD_IR)  ir_q <= ir_sr;
  end

  assign ir_so = ir_sr[0];

  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TAP_CAP_IR) |=> (ir_sr == IR_CAPTURE)); // R3

  AST_IR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (state != TAP_UPD_IR && state != TAP_RESET) |-> (ir_q == $past(ir_q))); // R3

endmodule

// File: rtl/dbg_tap_dr.sv
module dbg_tap_dr
  import dbg_tap_pkg::*;
#(
  parameter int           DW      = 32,
  parameter logic [DW-1:0] ID_CODE = 32'h2B5A_C0DF
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          tdi,
  input  tap_state_e    state,
  input  logic          sel_id,
  input  logic          sel_dbg,
  input  logic          sel_byp,
  input  logic [DW-1:0] dbg_rdata,
  output logic          byp_so,
  output logic          wide_so,
  output logic [DW-1:0] wide_q
);

  logic          byp_q;
  logic [DW-1:0] wide_sr;
  logic          wide_on;

  assign wide_on = sel_id | sel_dbg;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
    end else if (state == TAP_CAP_DR) begin
      byp_q <= 1'b0;
    end else if (state == TAP_SH_DR) begin
      byp_q <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      wide_sr <= '0;
    end else if (state == TAP_CAP_DR) begin
      if (sel_id)       wide_sr <= ID_CODE;
      else if (sel_dbg) wide_sr <= dbg_rdata;
    end else if (state == TAP_SH_DR && wide_on) begin
      wide_sr <= {tdi, wide_sr[DW-1:1]};
    end
  end

  assign byp_so  = byp_q;
  assign wide_so = wide_sr[0];
  assign wide_q  = wide_sr;

  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TAP_CAP_DR && sel_byp) |=> (byp_q == 1'b0)); // R5

  AST_ID_LOADED: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TAP_CAP_DR && sel_id) |=> (wide_sr == ID_CODE)); // R4

  AST_DBG_SNAPSHOT: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TAP_CAP_DR && sel_dbg) |=> (wide_sr == $past(dbg_rdata))); // R6

  AST_WINDOW_STILL_IN_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TAP_UPD_DR) |=> $stable(wide_sr)); // R7

endmodule

// File: rtl/dbg_tap_top.sv
module dbg_tap_top
  import dbg_tap_pkg::*;
#(
  parameter int            DW      = 32,
  parameter int            AW      = 4,
  parameter logic [DW-1:0] ID_CODE = 32'h2B5A_C0DF
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          tms,
  input  logic          tdi,
  output logic          tdo,
  output logic          tdo_oe,
  output logic [AW-1:0] dbg_addr,
  output logic          dbg_rd_en,
  input  logic [DW-1:0] dbg_rdata,
  output logic          dbg_wr_en,
  output logic [DW-1:0] dbg_wdata,
  output logic          bs_select,
  output logic          bs_extest,
  output logic          bs_capture,
  output logic          bs_shift,
  output logic          bs_update,
  input  logic          bs_tdo
);

  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_so, byp_so, wide_so;
  logic            sel_id, sel_dbg, sel_byp, sel_ext, sel_smp, sel_bs;
  logic            tdo_d, oe_d;

  dbg_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  dbg_tap_ir u_ir (
    .tck    (tck),
    .trst_n (trst_n),
    .tdi    (tdi),
    .state  (state),
    .ir_q   (ir_q),
    .ir_so  (ir_so)
  );

  always_comb begin
    sel_ext = (ir_q == OP_EXTEST);
    sel_smp = (ir_q == OP_SAMPLE);
    sel_id  = (ir_q == OP_IDCODE);
    sel_dbg = (ir_q[IR_W-1:IR_W-2] == OP_DBG_HI);
    sel_bs  = sel_ext | sel_smp;
    sel_byp = !(sel_bs | sel_id | sel_dbg);
  end

  dbg_tap_dr #(.DW(DW), .ID_CODE(ID_CODE)) u_dr (
    .tck       (tck),
    .trst_n    (trst_n),
    .tdi       (tdi),
    .state     (state),
    .sel_id    (sel_id),
    .sel_dbg   (sel_dbg),
    .sel_byp   (sel_byp),
    .dbg_rdata (dbg_rdata),
    .byp_so    (byp_so),
    .wide_so   (wide_so),
    .wide_q    (dbg_wdata)
  );

  assign dbg_addr   = ir_q[AW-1:0];
  assign dbg_rd_en  = sel_dbg && (state == TAP_CAP_DR);
  assign dbg_wr_en  = sel_dbg && (state == TAP_UPD_DR);
  assign bs_select  = sel_bs;
  assign bs_extest  = sel_ext;
  assign bs_capture = sel_bs && (state == TAP_CAP_DR);
  assign bs_shift   = sel_bs && (state == TAP_SH_DR);
  assign bs_update  = sel_bs && (state == TAP_UPD_DR);

  always_comb begin
    oe_d  = 1'b0;
    tdo_d = 1'b0;
    if (state == TAP_SH_IR) begin
      oe_d  = 1'b1;
      tdo_d = ir_so;
    end else if (state == TAP_SH_DR) begin
      oe_d = 1'b1;
      if (sel_bs)                tdo_d = bs_tdo;
      else if (sel_id | sel_dbg) tdo_d = wide_so;
      else                       tdo_d = byp_so;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= oe_d;
    end
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({dbg_rd_en, dbg_wr_en, bs_capture, bs_shift, bs_update})); // R8

  AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_oe |-> (tdo == 1'b0)); // R9

  AST_WRITE_ADDR_STEADY: assert property (@(posedge tck) disable iff (!trst_n)
    dbg_wr_en |-> $stable(dbg_addr)); // R7

endmodule

// File: tb/dbg_tap_top_tb.sv
module dbg_tap_top_tb;

  localparam logic [31:0] ID = 32'h2B5A_C0DF;

  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic        tdo, tdo_oe;
  logic [3:0]  dbg_addr;
  logic        dbg_rd_en, dbg_wr_en;
  logic [31:0] dbg_rdata, dbg_wdata;
  logic        bs_select, bs_extest, bs_capture, bs_shift, bs_update;
  logic        bs_tdo;

  always #5 tck = ~tck;

  dbg_tap_top u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .dbg_addr(dbg_addr), .dbg_rd_en(dbg_rd_en), .dbg_rdata(dbg_rdata),
    .dbg_wr_en(dbg_wr_en), .dbg_wdata(dbg_wdata),
    .bs_select(bs_select), .bs_extest(bs_extest), .bs_capture(bs_capture),
    .bs_shift(bs_shift), .bs_update(bs_update), .bs_tdo(bs_tdo)
  );

  logic [31:0] bank [16];
  logic [7:0]  chain;

  initial begin
    for (int i = 0; i < 16; i++) bank[i] = 32'h1000_0000 + 32'(i) * 32'h0111_0111;
  end
  assign dbg_rdata = bank[dbg_addr];
  always @(negedge tck) if (dbg_wr_en) bank[dbg_addr] <= dbg_wdata;

  always @(posedge tck) begin
    if (bs_capture)    chain <= 8'h3C;
    else if (bs_shift) chain <= {tdi, chain[7:1]};
  end
  assign bs_tdo = chain[0];

  int   errors = 0;
  int   checks = 0;
  bit   done = 0;
  logic s_rd, s_wr, s_bsc, s_bss, s_bsu, s_oe;
  logic cap_rd, cap_bs, upd_wr, upd_bs, sh_bs, oe_all, edge_ok;
  logic [31:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    tms = m; tdi = d;
    #2;
    o = tdo; s_oe = tdo_oe;
    s_rd = dbg_rd_en; s_wr = dbg_wr_en;
    s_bsc = bs_capture; s_bss = bs_shift; s_bsu = bs_update;
    @(posedge tck); #1;
    if (tdo !== o) edge_ok = 1'b0;
  endtask

  task automatic scan_ir(input logic [5:0] v, output logic [5:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 6; i++) begin
      step(i == 5, v[i], o);
      cap[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic o;
    dout = '0; oe_all = 1'b1; sh_bs = 1'b1; edge_ok = 1'b1;
    step(1, 0, o); step(0, 0, o);
    step(0, 0, o); cap_rd = s_rd; cap_bs = s_bsc;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
      oe_all &= s_oe; sh_bs &= s_bss;
    end
    step(1, 0, o); step(0, 0, o); upd_wr = s_wr; upd_bs = s_bsu;
  endtask

  // driver pushes expectations; monitor side pops and compares
  task automatic sb_push(input logic [31:0] v);
    exp_q.push_back(v);
  endtask

  task automatic sb_pop(input string tag, input logic [31:0] act);
    logic [31:0] e;
    e = exp_q.pop_front();
    chk(act === e, tag, act, e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [5:0]  ic;
    logic [31:0] r;
    logic        o;
    repeat (3) @(posedge tck);
    #3;
    chk(tdo_oe == 0 && tdo == 0, "R9 reset outputs quiet", {tdo_oe, tdo}, 0);
    chk(!bs_select && !dbg_rd_en && !dbg_wr_en, "R1 reset selects IDCODE", {bs_select, dbg_rd_en, dbg_wr_en}, 0);
    @(negedge tck); trst_n = 1'b1;
    step(0, 0, o);

    // R4 IDCODE twice, shifting junk in
    sb_push(ID); scan_dr(32, 32'hFFFF_0000, r); sb_pop("R4 idcode scan", r);
    chk(oe_all, "R9 oe in shift-dr", oe_all, 1);
    chk(edge_ok, "R9 tdo stable across rising edge", edge_ok, 1);
    sb_push(ID); scan_dr(32, 32'h0000_0000, r); sb_pop("R4 idcode unaltered", r);

    // R3 capture pattern; R5 bypass
    scan_ir(6'b111111, ic);
    chk(ic == 6'b000001, "R3 ir capture pattern", ic, 6'b000001);
    sb_push({24'h0, 8'b0110_1010}); scan_dr(8, 32'hB5, r); sb_pop("R5 bypass delay", r);
    scan_ir(6'b010101, ic);
    sb_push({24'h0, 8'b1001_1000}); scan_dr(8, 32'h4C, r); sb_pop("R5 unlisted opcode bypass", r);

    // R6/R7 debug register 3
    scan_ir(6'b100011, ic);
    chk(dbg_addr == 4'd3, "R6 debug address", dbg_addr, 3);
    sb_push(32'h1000_0000 + 3 * 32'h0111_0111);
    scan_dr(32, 32'hDEAD_BEEF, r); sb_pop("R6 debug snapshot", r);
    chk(cap_rd, "R6 read strobe in capture", cap_rd, 1);
    chk(upd_wr, "R7 write strobe in update", upd_wr, 1);
    chk(bank[3] == 32'hDEAD_BEEF, "R7 written register", bank[3], 32'hDEAD_BEEF);
    chk(bank[4] == 32'h1000_0000 + 4 * 32'h0111_0111, "R7 neighbour untouched", bank[4], 32'h1000_0000 + 4 * 32'h0111_0111);
    sb_push(32'hDEAD_BEEF); scan_dr(32, 32'h0BAD_F00D, r); sb_pop("R7 readback", r);

    // R6 debug register 15
    scan_ir(6'b101111, ic);
    sb_push(32'h1000_0000 + 15 * 32'h0111_0111);
    scan_dr(32, 32'h1234_5678, r); sb_pop("R6 debug addr 15", r);
    chk(bank[15] == 32'h1234_5678, "R7 write addr 15", bank[15], 32'h1234_5678);

    // R8 extest / sample
    scan_ir(6'b000000, ic);
    chk(bs_select && bs_extest, "R8 extest select", {bs_select, bs_extest}, 2'b11);
    sb_push(32'h3C); scan_dr(8, 32'h00, r); sb_pop("R8 chain routed", r);
    chk(cap_bs && sh_bs && upd_bs, "R8 chain strobes", {cap_bs, sh_bs, upd_bs}, 3'b111);
    scan_ir(6'b000001, ic);
    chk(bs_select && !bs_extest, "R8 sample select", {bs_select, bs_extest}, 2'b10);

    // R2 five ones from mid Shift-DR under bypass
    scan_ir(6'b111111, ic);
    step(1, 0, o); step(0, 0, o); step(0, 0, o); step(0, 1, o);
    repeat (5) step(1, 0, o);
    step(0, 0, o);
    sb_push(ID); scan_dr(32, 32'h0, r); sb_pop("R2 five ones restore idcode", r);

    // R1 asynchronous reset mid-operation
    scan_ir(6'b100001, ic);
    #2; trst_n = 1'b0; #1;
    chk(dbg_addr == 4'hF && !bs_select, "R1 async reset restores idcode", dbg_addr, 4'hF);
    @(negedge tck); trst_n = 1'b1;
    step(0, 0, o);
    sb_push(ID); scan_dr(32, 32'h0, r); sb_pop("R1 idcode after reset", r);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule